// File: doc/BRIEF.md
# Parallel Converter Scan Controller

This block runs on the host side of a simultaneous-sampling analog-to-digital converter that exposes its results through a small parallel register port. A one-cycle trigger starts a scan. The controller drives the channel-set mode and the auxiliary-input select, waits a set number of host clocks, and then pulses convert-start. It then waits for the converter's active-low busy line to drop and rise again, which marks fresh results. After that it reads each converted channel's result register with an active-low chip select, an active-low read strobe and a 2-bit register address.

Each register read produces one output beat. A beat carries the register address as the channel tag and the 11-bit two's-complement value taken from the upper bits of the 12-bit bus, marked by a one-cycle valid strobe. A one-cycle done pulse closes the scan. If the busy handshake does not finish within a bound, the scan ends with a one-cycle timeout pulse and no reads. All setup, strobe and timeout intervals are parameters counted in host clocks.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is high and right after it: cs_n_o and rd_n_o are 1; conv_o, res_valid_o, done_o and timeout_o are 0; mode_o and aux_sel_o are 0.
- R2: A trigger seen in idle copies mode_cfg_i to mode_o and aux_cfg_i to aux_sel_o in the next cycle. conv_o rises SETUP_CYC cycles after that and stays high for exactly CONV_CYC cycles. mode_o and aux_sel_o stay unchanged until the scan ends.
- R3: cs_n_o is low and addr_o is valid at least one cycle before rd_n_o falls. Both hold for the whole low phase of rd_n_o and through the high phase that follows it.
- R4: rd_n_o stays low for exactly RD_LO_CYC cycles per read. Between two reads of one scan it stays high for at least RD_HI_CYC cycles. The bus is captured on the last low cycle, and res_valid_o pulses in the cycle where rd_n_o returns high.
- R5: The addresses read depend on mode_o. Mode 0 reads addresses 1 and 2. Mode 1 reads 1, 2 and 3. Mode 2 reads 0, 1 and 2. Mode 3 reads 0, 1, 2 and 3. Reads run in ascending address order, and res_chan_o equals the address read.
- R6: res_data_o is bus bits 11:1 taken as a signed value. Bus bit 0 has no effect on it.
- R7: Reads start only after busy_n_i has been seen low and then high. The first chip-select fall comes SYNC_STG+1 cycles after busy_n_i rises.
- R8: done_o pulses for one cycle exactly RD_HI_CYC cycles after the last valid beat, in the same cycle that cs_n_o returns high.
- R9: If busy_n_i does not complete low-then-high within TIMEOUT_CYC cycles after conv_o falls, timeout_o pulses exactly TIMEOUT_CYC cycles after that fall. In that case no read, no valid beat and no done pulse occurs.
- R10: A trigger that arrives while a scan is in progress is ignored: it causes no second convert-start pulse, and the scan's results are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Scan request, accepted in idle only |
| mode_cfg_i | input | 2 | Channel-set selection for the next scan |
| aux_cfg_i | input | 2 | Auxiliary input selection for the next scan |
| busy_n_i | input | 1 | Converter busy, low while converting (asynchronous) |
| bus_i | input | DATA_W | Converter parallel data bus |
| mode_o | output | 2 | Channel-set mode driven to the converter |
| aux_sel_o | output | 2 | Auxiliary input select driven to the converter |
| conv_o | output | 1 | Convert-start pulse |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| addr_o | output | 2 | Result register address |
| res_valid_o | output | 1 | Result beat strobe |
| res_chan_o | output | 2 | Channel tag of the beat |
| res_data_o | output | DATA_W-1 | Signed result value |
| done_o | output | 1 | Scan finished pulse |
| timeout_o | output | 1 | Busy handshake timed out pulse |

## Verification
The hardest states to reach are the two partial handshakes: busy dropping but never returning, and busy never dropping at all. A correct converter never produces either one. The bench therefore drives busy_n_i from its own converter model. That model has per-run controls for the delay before the low phase, the length of the low phase, and whether either edge is withheld. Each control is used to force the timeout path and to measure its exact cycle. A second trigger is injected while busy is low, to show that a scan in flight cannot be restarted.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  localparam int ADDR_W = 2;
  localparam int N_SLOT = 1 << ADDR_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CONV,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_ADDR,
    ST_RD_LO,
    ST_RD_HI
  } scan_state_e;

  // Mode bit 1 adds slot 0, mode bit 0 adds slot 3; slots 1 and 2 always read.
  function automatic logic [N_SLOT-1:0] slot_mask(input logic [1:0] m);
    return {m[0], 1'b1, 1'b1, m[1]};
  endfunction

endpackage

// File: rtl/adc_scan_timer.sv
module adc_scan_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_scan_chmap.sv
module adc_scan_chmap
  import adc_scan_pkg::*;
(
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] cur_i,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] next_o,
  output logic              has_next_o
);

  logic [N_SLOT-1:0] mask;

  assign mask = slot_mask(mode_i);

  // Scan downward so the last hit is the lowest qualifying slot.
  always_comb begin
    first_o    = '0;
    next_o     = '0;
    has_next_o = 1'b0;
    for (int i = N_SLOT - 1; i >= 0; i--) begin
      if (mask[i]) begin
        first_o = ADDR_W'(i);
      end
      if (mask[i] && (i > int'(cur_i))) begin
        next_o     = ADDR_W'(i);
        has_next_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SETUP_CYC   = 4,
  parameter int CONV_CYC    = 2,
  parameter int RD_LO_CYC   = 3,
  parameter int RD_HI_CYC   = 3,
  parameter int TIMEOUT_CYC = 2000,
  parameter int SYNC_STG    = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     trig_i,
  input  logic [1:0]               mode_cfg_i,
  input  logic [1:0]               aux_cfg_i,
  input  logic                     busy_n_i,
  input  logic [DATA_W-1:0]        bus_i,
  output logic [1:0]               mode_o,
  output logic [1:0]               aux_sel_o,
  output logic                     conv_o,
  output logic                     cs_n_o,
  output logic                     rd_n_o,
  output logic [ADDR_W-1:0]        addr_o,
  output logic                     res_valid_o,
  output logic [ADDR_W-1:0]        res_chan_o,
  output logic signed [DATA_W-2:0] res_data_o,
  output logic                     done_o,
  output logic                     timeout_o
);

  localparam int PH_MAX_A = (SETUP_CYC > CONV_CYC) ? SETUP_CYC : CONV_CYC;
  localparam int PH_MAX_B = (RD_LO_CYC > RD_HI_CYC) ? RD_LO_CYC : RD_HI_CYC;
  localparam int PH_MAX   = (PH_MAX_A > PH_MAX_B) ? PH_MAX_A : PH_MAX_B;
  localparam int PH_W     = $clog2(PH_MAX + 1);
  localparam int TO_W     = $clog2(TIMEOUT_CYC + 1);

  scan_state_e st_q, st_nx;

  logic [SYNC_STG-1:0] sync_q;
  logic                busy_s;
  logic                ph_load, ph_zero;
  logic [PH_W-1:0]     ph_val;
  logic                to_load, to_zero;
  logic                cap, evt_done, evt_tmo;
  logic [ADDR_W-1:0]   first_addr, next_addr;
  logic                has_next;
  logic                bus_lsb_unused;

  assign bus_lsb_unused = bus_i[0];

  // Busy arrives from the converter clock domain.
  generate
    if (SYNC_STG == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= busy_n_i;
      end
    end else begin : g_sync_many
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STG-2:0], busy_n_i};
      end
    end
  endgenerate

  assign busy_s = sync_q[SYNC_STG-1];

  adc_scan_timer #(.W(PH_W)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .load_i (ph_load),
    .val_i  (ph_val),
    .zero_o (ph_zero)
  );

  adc_scan_timer #(.W(TO_W)) u_watch (
    .clk    (clk),
    .rst    (rst),
    .load_i (to_load),
    .val_i  (TO_W'(TIMEOUT_CYC - 1)),
    .zero_o (to_zero)
  );

  adc_scan_chmap u_map (
    .mode_i     (mode_o),
    .cur_i      (addr_o),
    .first_o    (first_addr),
    .next_o     (next_addr),
    .has_next_o (has_next)
  );

  always_comb begin
    st_nx    = st_q;
    ph_load  = 1'b0;
    ph_val   = '0;
    to_load  = 1'b0;
    cap      = 1'b0;
    evt_done = 1'b0;
    evt_tmo  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (trig_i) begin
          st_nx   = ST_SETUP;
          ph_load = 1'b1;
          ph_val  = PH_W'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (ph_zero) begin
          st_nx   = ST_CONV;
          ph_load = 1'b1;
          ph_val  = PH_W'(CONV_CYC - 1);
        end
      end
      ST_CONV: begin
        if (ph_zero) begin
          st_nx   = ST_WAIT_LO;
          to_load = 1'b1;
        end
      end
      ST_WAIT_LO: begin
        if (!busy_s) begin
          st_nx = ST_WAIT_HI;
        end else if (to_zero) begin
          st_nx   = ST_IDLE;
          evt_tmo = 1'b1;
        end
      end
      ST_WAIT_HI: begin
        if (busy_s) begin
          st_nx = ST_ADDR;
        end else if (to_zero) begin
          st_nx   = ST_IDLE;
          evt_tmo = 1'b1;
        end
      end
      ST_ADDR: begin
        st_nx   = ST_RD_LO;
        ph_load = 1'b1;
        ph_val  = PH_W'(RD_LO_CYC - 1);
      end
      ST_RD_LO: begin
        if (ph_zero) begin
          st_nx   = ST_RD_HI;
          ph_load = 1'b1;
          ph_val  = PH_W'(RD_HI_CYC - 1);
          cap     = 1'b1;
        end
      end
      ST_RD_HI: begin
        if (ph_zero) begin
          if (has_next) begin
            st_nx = ST_ADDR;
          end else begin
            st_nx    = ST_IDLE;
            evt_done = 1'b1;
          end
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      mode_o      <= '0;
      aux_sel_o   <= '0;
      conv_o      <= 1'b0;
      cs_n_o      <= 1'b1;
      rd_n_o      <= 1'b1;
      addr_o      <= '0;
      res_valid_o <= 1'b0;
      res_chan_o  <= '0;
      res_data_o  <= '0;
      done_o      <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      st_q        <= st_nx;
      res_valid_o <= cap;
      done_o      <= evt_done;
      timeout_o   <= evt_tmo;
      conv_o      <= (st_nx == ST_CONV);
      cs_n_o      <= !((st_nx == ST_ADDR) || (st_nx == ST_RD_LO) || (st_nx == ST_RD_HI));
      rd_n_o      <= (st_nx != ST_RD_LO);
      if (st_q == ST_IDLE && trig_i) begin
        mode_o    <= mode_cfg_i;
        aux_sel_o <= aux_cfg_i;
      end
      if (st_q == ST_WAIT_HI && st_nx == ST_ADDR) begin
        addr_o <= first_addr;
      end else if (st_q == ST_RD_HI && st_nx == ST_ADDR) begin
        addr_o <= next_addr;
      end
      if (cap) begin
        res_chan_o <= addr_o;
        res_data_o <= bus_i[DATA_W-1:1];
      end
    end
  end

endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode_o,
  input logic [1:0] aux_sel_o,
  input logic       conv_o,
  input logic       cs_n_o,
  input logic       rd_n_o,
  input logic [1:0] addr_o,
  input logic       res_valid_o,
  input logic       done_o,
  input logic       timeout_o
);

  AST_RD_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    !rd_n_o |-> !cs_n_o); // R3

  AST_ADDR_HELD_LOW: assert property (@(posedge clk) disable iff (rst)
    (!rd_n_o && $past(!rd_n_o)) |-> $stable(addr_o)); // R3

  AST_SELECT_BEFORE_RD: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n_o) |-> ($past(!cs_n_o) && $stable(addr_o))); // R3

  AST_VALID_AT_RD_RISE: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> $rose(rd_n_o)); // R4

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_o && $past(!cs_n_o)) |-> ($stable(mode_o) && $stable(aux_sel_o))); // R2

  AST_DONE_RELEASES_CS: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($rose(cs_n_o) && !timeout_o)); // R8

  AST_TIMEOUT_NO_READ: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (cs_n_o && $past(cs_n_o) && !res_valid_o)); // R9

  AST_NO_CONV_IN_READ: assert property (@(posedge clk) disable iff (rst)
    conv_o |-> (cs_n_o && rd_n_o)); // R10

endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_o      (mode_o),
  .aux_sel_o   (aux_sel_o),
  .conv_o      (conv_o),
  .cs_n_o      (cs_n_o),
  .rd_n_o      (rd_n_o),
  .addr_o      (addr_o),
  .res_valid_o (res_valid_o),
  .done_o      (done_o),
  .timeout_o   (timeout_o)
);

// File: tb/adc_scan_ctrl_tb_top.sv
module adc_scan_ctrl_tb_top;

  localparam int CLK_P = 10;
  localparam int SETUP = 3;
  localparam int CONVC = 2;
  localparam int RDLO  = 3;
  localparam int RDHI  = 2;
  localparam int TMO   = 60;
  localparam int SYNC  = 2;

  // {mode[15:14], aux[13:12], base word[11:0]}
  localparam logic [15:0] VEC [8] = '{
    {2'd0, 2'd1, 12'h123}, {2'd1, 2'd2, 12'h801}, {2'd2, 2'd3, 12'hFFF},
    {2'd3, 2'd0, 12'h7FE}, {2'd3, 2'd2, 12'hA55}, {2'd2, 2'd1, 12'h3C3},
    {2'd1, 2'd0, 12'h000}, {2'd0, 2'd3, 12'hE01}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              trig_i = 1'b0;
  logic [1:0]        mode_cfg_i = '0;
  logic [1:0]        aux_cfg_i = '0;
  logic              busy_n_i = 1'b1;
  logic [11:0]       bus_i;
  logic [1:0]        mode_o, aux_sel_o, addr_o, res_chan_o;
  logic              conv_o, cs_n_o, rd_n_o, res_valid_o, done_o, timeout_o;
  logic signed [10:0] res_data_o;
  logic [11:0]       mem [4];

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  assign bus_i = (!cs_n_o && !rd_n_o) ? mem[addr_o] : 12'h5A5;

  adc_scan_ctrl #(
    .DATA_W(12), .SETUP_CYC(SETUP), .CONV_CYC(CONVC), .RD_LO_CYC(RDLO),
    .RD_HI_CYC(RDHI), .TIMEOUT_CYC(TMO), .SYNC_STG(SYNC)
  ) dut_i (
    .clk(clk), .rst(rst), .trig_i(trig_i), .mode_cfg_i(mode_cfg_i),
    .aux_cfg_i(aux_cfg_i), .busy_n_i(busy_n_i), .bus_i(bus_i),
    .mode_o(mode_o), .aux_sel_o(aux_sel_o), .conv_o(conv_o), .cs_n_o(cs_n_o),
    .rd_n_o(rd_n_o), .addr_o(addr_o), .res_valid_o(res_valid_o),
    .res_chan_o(res_chan_o), .res_data_o(res_data_o), .done_o(done_o),
    .timeout_o(timeout_o)
  );

  // Monitor: samples at the falling edge only.
  int cyc = 0, t_trig = 0, t_rise = 0, t_fall = 0, t_brise = 0, t_cs = -1;
  int t_done = 0, t_tmo = 0, t_lastv = 0;
  int n_conv = 0, n_done = 0, n_tmo = 0, n_res = 0, rd_bad = 0;
  int lo_len = 0, hi_len = 0;
  bit gap_on = 1'b0, done_cs = 1'b0;
  logic [1:0] lo_addr = '0, mode_at = '0, aux_at = '0;
  logic [1:0] got_ch [8];
  logic signed [10:0] got_d [8];
  logic p_trig = 1'b0, p_conv = 1'b0, p_busy = 1'b1, p_cs = 1'b1, p_rd = 1'b1;

  always @(negedge clk) begin
    cyc++;
    if (trig_i && !p_trig) t_trig = cyc;
    if (conv_o && !p_conv) begin
      t_rise = cyc; n_conv++; n_res = 0; t_cs = -1;
      mode_at = mode_o; aux_at = aux_sel_o;
    end
    if (!conv_o && p_conv) t_fall = cyc;
    if (busy_n_i && !p_busy) t_brise = cyc;
    if (!cs_n_o && p_cs && t_cs < 0) t_cs = cyc;
    if (!rd_n_o) begin
      if (p_rd) begin
        lo_len = 1; lo_addr = addr_o;
        if (gap_on && hi_len < RDHI) rd_bad++;
      end else begin
        lo_len++;
        if (addr_o != lo_addr) rd_bad++;
      end
      if (cs_n_o) rd_bad++;
    end else begin
      if (!p_rd) begin
        if (lo_len != RDLO) rd_bad++;
        hi_len = 0; gap_on = 1'b1;
      end
      if (!cs_n_o) hi_len++;
      else gap_on = 1'b0;
    end
    if (res_valid_o) begin
      if (rd_n_o && p_rd) rd_bad++;
      if (n_res < 8) begin got_ch[n_res] = res_chan_o; got_d[n_res] = res_data_o; end
      n_res++; t_lastv = cyc;
    end
    if (done_o) begin n_done++; t_done = cyc; done_cs = cs_n_o; end
    if (timeout_o) begin n_tmo++; t_tmo = cyc; end
    p_trig = trig_i; p_conv = conv_o; p_busy = busy_n_i; p_cs = cs_n_o; p_rd = rd_n_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [3:0] exp_mask(input logic [1:0] m);
    logic [3:0] r;
    r[0] = (m == 2'd2) || (m == 2'd3);
    r[1] = 1'b1;
    r[2] = 1'b1;
    r[3] = (m == 2'd1) || (m == 2'd3);
    return r;
  endfunction

  task automatic fill_mem(input logic [11:0] base);
    for (int a = 0; a < 4; a++) mem[a] = 12'(base + a * 12'h3C5);
  endtask

  // One scan; converter model drives busy_n_i.
  task automatic run_scan(input logic [1:0] m, input logic [1:0] x, input int lo_dly,
                          input int lo_len_c, input bit no_low, input bit no_high,
                          input bit extra_trig);
    int d0, t0, w;
    d0 = n_done; t0 = n_tmo;
    mode_cfg_i = m; aux_cfg_i = x;
    tick(); trig_i = 1'b1;
    tick(); trig_i = 1'b0;
    w = 0;
    while (!conv_o && w < 100) begin tick(); w++; end
    repeat (lo_dly) tick();
    if (!no_low) busy_n_i = 1'b0;
    if (extra_trig) begin
      mode_cfg_i = ~m; trig_i = 1'b1; tick(); trig_i = 1'b0;
    end
    repeat (lo_len_c) tick();
    if (!no_low && !no_high) busy_n_i = 1'b1;
    w = 0;
    while (n_done == d0 && n_tmo == t0 && w < TMO + 200) begin tick(); w++; end
    repeat (3) tick();
    busy_n_i = 1'b1;
  endtask

  task automatic check_results(input logic [1:0] m, input string tag);
    logic [3:0] mk;
    int k;
    logic signed [10:0] e;
    mk = exp_mask(m);
    check(n_res == $countones(mk), {tag, " R5 count"}, n_res, $countones(mk));
    k = 0;
    for (int a = 0; a < 4; a++) begin
      if (mk[a] && k < n_res && k < 8) begin
        e = mem[a][11:1];
        check(got_ch[k] == 2'(a), {tag, " R5 order"}, int'(got_ch[k]), a);
        check(got_d[k] == e, {tag, " R6 data"}, int'(got_d[k]), int'(e));
        k++;
      end
    end
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    fill_mem(12'h000);
    repeat (3) tick();
    @(negedge clk);
    // R1 reset state
    check(cs_n_o && rd_n_o, "R1 strobes idle", {cs_n_o, rd_n_o}, 3);
    check(!conv_o && !res_valid_o && !done_o && !timeout_o, "R1 pulses low",
          {conv_o, res_valid_o, done_o, timeout_o}, 0);
    check(mode_o == 2'd0 && aux_sel_o == 2'd0, "R1 cfg outputs", {mode_o, aux_sel_o}, 0);
    tick(); rst = 1'b0;
    tick();
    @(negedge clk);
    check(cs_n_o && rd_n_o && !conv_o, "R1 after release", {cs_n_o, rd_n_o, conv_o}, 6);

    // Vector walk
    for (int i = 0; i < 8; i++) begin
      logic [1:0] m, x;
      int c0;
      m = VEC[i][15:14]; x = VEC[i][13:12];
      fill_mem(VEC[i][11:0]);
      c0 = n_conv;
      rd_bad = 0;
      run_scan(m, x, 1 + (i % 3), 5 + i, 1'b0, 1'b0, 1'b0);
      check(n_conv == c0 + 1, "R2 one convert pulse", n_conv - c0, 1);
      check(t_rise - t_trig == SETUP + 1, "R2 setup delay", t_rise - t_trig, SETUP + 1);
      check(t_fall - t_rise == CONVC, "R2 pulse width", t_fall - t_rise, CONVC);
      check(mode_at == m && aux_at == x, "R2 cfg at convert", {mode_at, aux_at}, {m, x});
      check(t_cs - t_brise == SYNC + 1, "R7 read start", t_cs - t_brise, SYNC + 1);
      check(rd_bad == 0, "R3 R4 strobe timing", rd_bad, 0);
      check(t_done - t_lastv == RDHI && done_cs, "R8 done timing", t_done - t_lastv, RDHI);
      check_results(m, "vec");
    end

    // Timeout: busy never drops
    begin
      int r0, d0;
      r0 = n_tmo; d0 = n_done;
      fill_mem(12'h111);
      run_scan(2'd3, 2'd0, 1, 5, 1'b1, 1'b0, 1'b0);
      check(n_tmo == r0 + 1, "R9 timeout no low", n_tmo - r0, 1);
      check(t_tmo - t_fall == TMO, "R9 timeout cycle", t_tmo - t_fall, TMO);
      check(n_res == 0 && n_done == d0, "R9 no reads", n_res, 0);
      check(t_cs < 0, "R7 no select without busy", t_cs, -1);
    end

    // Timeout: busy drops but never returns
    begin
      int r0, d0;
      r0 = n_tmo; d0 = n_done;
      run_scan(2'd1, 2'd1, 2, 5, 1'b0, 1'b1, 1'b0);
      check(n_tmo == r0 + 1, "R9 timeout stuck low", n_tmo - r0, 1);
      check(t_tmo - t_fall == TMO, "R9 stuck-low cycle", t_tmo - t_fall, TMO);
      check(n_res == 0 && n_done == d0 && t_cs < 0, "R7 R9 no read while low", n_res, 0);
    end

    // Second trigger during a scan
    begin
      int c0;
      c0 = n_conv;
      fill_mem(12'h9B7);
      run_scan(2'd2, 2'd2, 1, 8, 1'b0, 1'b0, 1'b1);
      repeat (20) tick();
      check(n_conv == c0 + 1, "R10 retrigger ignored", n_conv - c0, 1);
      check(mode_o == 2'd2, "R10 mode kept", int'(mode_o), 2);
      check_results(2'd2, "R10");
    end

    // Bit 0 of the bus has no effect
    begin
      mem[0] = 12'h001; mem[1] = 12'hFFE; mem[2] = 12'hFFF; mem[3] = 12'h000;
      run_scan(2'd3, 2'd3, 1, 6, 1'b0, 1'b0, 1'b0);
      check(n_res == 4 && got_d[0] == 11'sd0 && got_d[1] == got_d[2],
            "R6 lsb dropped", int'(got_d[0]), 0);
      check(got_d[1] == -11'sd1, "R6 negative value", int'(got_d[1]), -1);
    end

    finish_run();
  end

endmodule